// File: doc/BRIEF.md
# Single-Line Open-Drain Bus Master Slot Engine

This block drives a single-wire open-drain bus as its only master. A host issues one command at a time: a bus reset, a one-bit write or a one-bit read. The block turns each command into a timed low pulse on a drive-low enable, which an external open-drain pad turns into a low on the wire. It then watches the wire level through a two-flop synchronizer and reports what it saw.

All timing is counted in microseconds. A divider derived from the clock-frequency parameter produces one tick per microsecond, and every pulse width, sample point and slot length is a whole number of these ticks. After a reset, the block reports whether any slave answered with a presence pulse. After a read, it returns the sampled bit. Either result is valid on the cycle of a one-cycle done strobe. A busy flag covers the whole slot including its released recovery time, and commands that arrive while it is set are dropped.

Command codes on `cmd_op`: 0 = bus reset, 1 = write bit (`cmd_wbit` selects the value), 2 = read bit, 3 = reserved and ignored.

Top module: `owm_master`

## Requirements
- R1: A reset command (code 0) drives the line low for exactly T_RST_LOW µs (default 500, always within 480 to 960 µs), then keeps the line released so that busy lasts T_RST_LOW + T_RST_REL µs in total (default 980).
- R2: During a reset, the synchronized line is sampled T_PRES_SMP µs after release (default 70). A low sample sets `presence` to 1 and a high sample sets it to 0, and the result is updated on the done strobe.
- R3: A write command (code 1) with `cmd_wbit`=0 holds the line low for T_W0_LOW µs (default 65, within 60 to 120 µs).
- R4: A write command with `cmd_wbit`=1 holds the line low for T_SHORT_LOW µs (default 6, within 1 to 15 µs).
- R5: A read command (code 2) holds the line low for T_SHORT_LOW µs and samples the synchronized line T_RD_SMP µs after the slot start (default 12, below 15). A low sample returns `rd_bit`=0, a high sample returns 1, and the result is valid with `done`.
- R6: Every write or read slot keeps busy for T_SLOT + T_REC µs (default 72), so it lasts at least 61 µs and ends with at least 1 µs of released line.
- R7: A command presented while busy is set, or with the reserved code 3, starts nothing: busy stays as it was and the line is not driven because of it.
- R8: After the synchronous reset `rst`, `drive_low`, `busy`, `done`, `presence` and `rd_bit` are all 0, and `drive_low` is 0 whenever `busy` is 0.
- R9: Outside a bus reset, the line is never held low for 120 µs or longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when busy is 0 |
| cmd_op | input | 2 | Command code: 0 reset, 1 write, 2 read, 3 reserved |
| cmd_wbit | input | 1 | Bit value for a write |
| line_in | input | 1 | Raw wire level from the pad |
| drive_low | output | 1 | Pad enable: 1 pulls the wire low |
| busy | output | 1 | Slot or reset sequence in progress |
| done | output | 1 | One-cycle strobe at the end of each command |
| presence | output | 1 | 1 if a slave answered the last reset |
| rd_bit | output | 1 | Bit returned by the last read |

## Verification
The bench plays a slave on the wire. It answers a reset after a short delay and pulls the line during read slots when it must return a 0, so a design that sampled presence at the wrong offset, or sampled a read bit after the slave let go, would report the wrong bit. It measures the low time and busy time of every slot to the exact cycle, which catches a write that confuses the 0 and 1 pulse widths or a slot that drops its recovery time. Directed tests throw a reset command into a running write slot and issue the reserved code. A design that queued or accepted either would stretch the slot or start a spurious pulse.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_REL  = 2'd2
  } phase_e;
endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/owm_ticker.sv
module owm_ticker #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) cnt <= '0;
    else if (cnt == LAST)     cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/owm_slot_fsm.sv
module owm_slot_fsm
  import owm_pkg::*;
#(
  parameter int T_RST_LOW   = 500,
  parameter int T_RST_REL   = 480,
  parameter int T_PRES_SMP  = 70,
  parameter int T_W0_LOW    = 65,
  parameter int T_SHORT_LOW = 6,
  parameter int T_RD_SMP    = 12,
  parameter int T_SLOT      = 70,
  parameter int T_REC       = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  input  logic       line_s,
  input  logic       tick,
  output logic       start,
  output logic       busy,
  output logic       drive_low,
  output logic       done,
  output logic       presence,
  output logic       rd_bit
);
  localparam int RST_TOTAL  = T_RST_LOW + T_RST_REL;
  localparam int SLOT_TOTAL = T_SLOT + T_REC;
  localparam int MAX_US     = (RST_TOTAL > SLOT_TOTAL) ? RST_TOTAL : SLOT_TOTAL;
  localparam int UW         = $clog2(MAX_US + 1);
  localparam int LIM_SLOT   = 120;
  localparam int LIM_RST    = 960;

  phase_e       ph;
  op_e          op_q;
  logic         wbit_q;
  logic         smp_q;
  logic [UW-1:0] us_cnt;
  logic [UW-1:0] us_nxt;
  logic [UW-1:0] low_len;
  logic [UW-1:0] smp_at;
  logic [UW-1:0] total;

  assign start  = (ph == PH_IDLE) && cmd_valid && (op_e'(cmd_op) != OP_NONE);
  assign us_nxt = us_cnt + 1'b1;

  always_comb begin
    low_len = UW'(T_SHORT_LOW);
    smp_at  = UW'(T_RD_SMP);
    total   = UW'(SLOT_TOTAL);
    case (op_q)
      OP_RESET: begin
        low_len = UW'(T_RST_LOW);
        smp_at  = UW'(T_RST_LOW + T_PRES_SMP);
        total   = UW'(RST_TOTAL);
      end
      OP_WRITE: if (!wbit_q) low_len = UW'(T_W0_LOW);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      op_q      <= OP_NONE;
      wbit_q    <= 1'b0;
      smp_q     <= 1'b1;
      us_cnt    <= '0;
      busy      <= 1'b0;
      drive_low <= 1'b0;
      done      <= 1'b0;
      presence  <= 1'b0;
      rd_bit    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          op_q      <= op_e'(cmd_op);
          wbit_q    <= cmd_wbit;
          us_cnt    <= '0;
          busy      <= 1'b1;
          drive_low <= 1'b1;
          ph        <= PH_LOW;
        end
        PH_LOW: if (tick) begin
          us_cnt <= us_nxt;
          if (us_nxt == low_len) begin
            drive_low <= 1'b0;
            ph        <= PH_REL;
          end
        end
        PH_REL: if (tick) begin
          us_cnt <= us_nxt;
          if (us_nxt == smp_at) smp_q <= line_s;
          if (us_nxt == total) begin
            busy <= 1'b0;
            done <= 1'b1;
            ph   <= PH_IDLE;
            if (op_q == OP_RESET) presence <= ~smp_q;
            if (op_q == OP_READ)  rd_bit   <= smp_q;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R8: the line is released whenever no command is running
  p_idle_released_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !drive_low);

  // R9: slot pulses stay below the bus-reset threshold
  p_short_low_r9: assert property (@(posedge clk) disable iff (rst)
    (drive_low && op_q != OP_RESET) |-> (us_cnt < UW'(LIM_SLOT)));

  // R1: reset pulse never exceeds its upper bound
  p_reset_cap_r1: assert property (@(posedge clk) disable iff (rst)
    (drive_low && op_q == OP_RESET) |-> (us_cnt < UW'(LIM_RST)));

  // R7: a running command is never replaced
  p_hold_op_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(op_q));

  // R6: an accepted command starts a driven slot on the next cycle
  p_accept_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op != 2'd3) |=> (busy && drive_low));

  // R2: done is a single-cycle strobe that ends a busy period
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/owm_master.sv
module owm_master #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int T_RST_LOW   = 500,
  parameter int T_RST_REL   = 480,
  parameter int T_PRES_SMP  = 70,
  parameter int T_W0_LOW    = 65,
  parameter int T_SHORT_LOW = 6,
  parameter int T_RD_SMP    = 12,
  parameter int T_SLOT      = 70,
  parameter int T_REC       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  input  logic       line_in,
  output logic       drive_low,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       rd_bit
);
  localparam int RAW_DIV = CLK_HZ / 1_000_000;
  localparam int DIV     = (RAW_DIV < 1) ? 1 : RAW_DIV;

  logic line_s;
  logic tick;
  logic start;

  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_in),
    .q   (line_s)
  );

  owm_ticker #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (start),
    .run   (busy),
    .tick  (tick)
  );

  owm_slot_fsm #(
    .T_RST_LOW   (T_RST_LOW),
    .T_RST_REL   (T_RST_REL),
    .T_PRES_SMP  (T_PRES_SMP),
    .T_W0_LOW    (T_W0_LOW),
    .T_SHORT_LOW (T_SHORT_LOW),
    .T_RD_SMP    (T_RD_SMP),
    .T_SLOT      (T_SLOT),
    .T_REC       (T_REC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_wbit  (cmd_wbit),
    .line_s    (line_s),
    .tick      (tick),
    .start     (start),
    .busy      (busy),
    .drive_low (drive_low),
    .done      (done),
    .presence  (presence),
    .rd_bit    (rd_bit)
  );
endmodule

// File: tb/tb_owm_master.sv
`timescale 1ns/1ps
module tb_owm_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int WATCHDOG   = 150_000;
  localparam int NV         = 7;

  // op, wbit, slave active, low us, busy us, expected bit (-1 none)
  localparam int VK[NV] = '{0, 0, 1, 1, 2, 2, 0};
  localparam int VW[NV] = '{0, 0, 0, 1, 0, 0, 0};
  localparam int VS[NV] = '{1, 0, 0, 0, 1, 0, 1};
  localparam int VL[NV] = '{500, 500, 65, 6, 6, 6, 500};
  localparam int VT[NV] = '{980, 980, 72, 72, 72, 72, 980};
  localparam int VB[NV] = '{1, 0, -1, -1, 0, 1, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_wbit = 1'b0;
  logic line_in;
  logic drive_low, busy, done, presence, rd_bit;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  int cur_kind = 3;
  bit slave_on = 1'b0;
  bit prev_dl = 1'b0;
  int rd_hold = 0;
  int pres_wait = 0;
  int pres_hold = 0;
  logic slave_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  owm_master #(.CLK_HZ(DIV * 1_000_000)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .line_in(line_in), .drive_low(drive_low),
    .busy(busy), .done(done), .presence(presence), .rd_bit(rd_bit)
  );

  assign slave_pull = (rd_hold != 0) || (pres_wait == 0 && pres_hold != 0);
  assign line_in = !(drive_low || slave_pull);

  // simple slave model on the wire
  always @(posedge clk) begin
    prev_dl <= drive_low;
    if (rd_hold != 0) rd_hold <= rd_hold - 1;
    if (pres_wait != 0) pres_wait <= pres_wait - 1;
    else if (pres_hold != 0) pres_hold <= pres_hold - 1;
    if (drive_low && !prev_dl && cur_kind == 2 && slave_on) rd_hold <= 30 * DIV;
    if (!drive_low && prev_dl && cur_kind == 0 && slave_on) begin
      pres_wait <= 20 * DIV;
      pres_hold <= 120 * DIV;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      summary();
    end
  end

  // issue one command and measure low and busy cycles up to done
  task automatic run_cmd(input int kind, input int wbit, input int slv,
                         input int inject_at,
                         output int low_c, output int busy_c);
    int guard;
    low_c = 0; busy_c = 0; guard = 0;
    cur_kind = kind; slave_on = (slv != 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(kind); cmd_wbit = wbit[0];
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done && guard < 10000) begin
      if (busy) busy_c++;
      if (drive_low) low_c++;
      if (inject_at >= 0 && busy_c == inject_at) begin
        cmd_valid = 1'b1; cmd_op = 2'd0;
      end else begin
        cmd_valid = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    int lc, bc;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 drive_low", int'(drive_low), 0);
    check("R8 busy", int'(busy), 0);
    check("R8 done", int'(done), 0);
    check("R8 presence", int'(presence), 0);
    check("R8 rd_bit", int'(rd_bit), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_cmd(VK[i], VW[i], VS[i], -1, lc, bc);
      if (VK[i] == 0) begin
        check("R1 reset low cycles", lc, VL[i] * DIV);
        check("R1 reset busy cycles", bc, VT[i] * DIV);
        check("R1 low within 480..960us", int'(lc >= 480*DIV && lc <= 960*DIV), 1);
        check("R2 presence", int'(presence), VB[i]);
      end else if (VK[i] == 1) begin
        check("R6 slot busy cycles", bc, VT[i] * DIV);
        check("R6 slot >=61us plus 1us recovery", int'(bc >= 62*DIV && bc - lc >= DIV), 1);
        if (VW[i] == 0) begin
          check("R3 write0 low cycles", lc, VL[i] * DIV);
          check("R3 write0 within 60..120us", int'(lc >= 60*DIV && lc <= 120*DIV), 1);
        end else begin
          check("R4 write1 low cycles", lc, VL[i] * DIV);
          check("R4 write1 within 1..15us", int'(lc >= DIV && lc <= 15*DIV), 1);
        end
        check("R9 slot low below 120us", int'(lc < 120*DIV), 1);
      end else begin
        check("R5 read low cycles", lc, VL[i] * DIV);
        check("R5 read bit", int'(rd_bit), VB[i]);
        check("R6 read busy cycles", bc, VT[i] * DIV);
      end
      @(negedge clk);
      check("R8 released after done", int'(drive_low || busy), 0);
    end

    // R7: reset request inside a write-1 slot must be dropped
    run_cmd(1, 1, 0, 20 * DIV, lc, bc);
    check("R7 busy unaffected by request", bc, 72 * DIV);
    check("R7 low unaffected by request", lc, 6 * DIV);
    @(negedge clk);
    check("R7 nothing queued busy", int'(busy), 0);
    check("R7 nothing queued line", int'(drive_low), 0);

    // R7: reserved code 3 starts nothing
    cmd_valid = 1'b1; cmd_op = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    check("R7 reserved busy", int'(busy), 0);
    check("R7 reserved line", int'(drive_low), 0);

    // R2/R5: results hold until the next command of their kind
    check("R2 presence held", int'(presence), 1);
    check("R5 rd_bit held", int'(rd_bit), 1);

    // R8: reset in the middle of a slot
    cur_kind = 1; slave_on = 1'b0;
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_wbit = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid-slot reset line", int'(drive_low), 0);
    check("R8 mid-slot reset busy", int'(busy), 0);
    check("R8 mid-slot reset presence", int'(presence), 0);
    rst = 1'b0;
    @(negedge clk);
    summary();
  end
endmodule